// File: doc/BRIEF.md
# Subroutine and Interrupt Stack Sequencer

This block runs the byte-by-byte stack traffic behind subroutine calls and returns, software interrupts, wait-for-interrupt and interrupt returns on a byte-wide memory stack. It holds the 16-bit stack pointer. The stack grows toward lower addresses, and the pointer always addresses the next free byte. A command arrives as an opcode byte, along with the register values that may need saving. The block then makes one memory access per clock. When the sequence ends, it moves the stack pointer, shows the restored register values and gives a one-cycle done pulse.

A call saves only the two-byte return address. An interrupt entry saves a nine-byte image made of the return address, both index registers, both accumulators and the condition code byte. The matching return commands read the same bytes back in reverse. After a wait-for-interrupt has saved its image, the block stays busy and signals that it is waiting. It leaves that state when the interrupt request input is seen. Memory reads are assumed to return data in the same cycle the address is driven.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer equals the parameter SP_INIT (default 0x01FF), and busy, done, waiting and mem_en are all low.
- R2: A call command (opcode 0x9D, 0xAD, 0xBD or 0x8D) writes the return address low byte to SP and then the high byte to SP-1, on consecutive cycles. The stack pointer ends at SP-2.
- R3: A subroutine return (opcode 0x39) reads the high byte from SP+1 and then the low byte from SP+2. It presents them on ret_out, and the stack pointer ends at SP+2.
- R4: A software interrupt (opcode 0x3F) writes nine bytes at SP, SP-1, down to SP-8, in this order: return low, return high, IY low, IY high, IX low, IX high, A, B, condition code. The stack pointer ends at SP-9.
- R5: An interrupt return (opcode 0x3B) reads SP+1 up to SP+9 and restores, in that order: condition code, B, A, IX high, IX low, IY high, IY low, return high, return low. The stack pointer ends at SP+9.
- R6: Each stack byte takes exactly one cycle with mem_en high. mem_we is high on every push byte and low on every pull byte, and successive addresses in a sequence differ by one.
- R7: done is high for exactly one cycle, in the cycle after the last byte access. The stack pointer changes in that same cycle and at no other time.
- R8: Wait-for-interrupt (opcode 0x3E) writes the same nine-byte image as R4. It then holds waiting and busy high until a cycle in which irq is high, and both drop in the following cycle.
- R9: A command that arrives while busy is high, or that carries any other opcode, is ignored: no memory access, no stack pointer change, no done.
- R10: ret_out, ix_out, iy_out, a_out, b_out and ccr_out keep their values until the next accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| ret_in | input | 16 | Return address to save |
| ix_in | input | 16 | IX value to save |
| iy_in | input | 16 | IY value to save |
| a_in | input | 8 | Accumulator A to save |
| b_in | input | 8 | Accumulator B to save |
| ccr_in | input | 8 | Condition code to save |
| irq | input | 1 | Interrupt request that ends the wait state |
| mem_addr | output | 16 | Stack byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid in the same cycle |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| ret_out | output | 16 | Restored return address |
| ix_out | output | 16 | Restored IX |
| iy_out | output | 16 | Restored IY |
| a_out | output | 8 | Restored A |
| b_out | output | 8 | Restored B |
| ccr_out | output | 8 | Restored condition code |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence or wait in progress |
| waiting | output | 1 | Parked after wait-for-interrupt |
| sp | output | 16 | Stack pointer |

## Verification
The hardest case to reach is the interrupt return whose restored values cannot have come from leftovers in the block's own frame register. A push also loads that register, so a check on the values right after a software interrupt would pass for the wrong reason. The stimulus therefore saves an interrupt image and then runs a call and return with unrelated values on top of it, which overwrites the internal copy. Only after that does it issue the interrupt return, so every restored field must come from memory in the right order. Commands sent in the middle of a sequence and during the wait state are checked to produce no stray accesses.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [15:0] SP_INIT = 16'h01FF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic [15:0] ret_in,
  input  logic [15:0] ix_in,
  input  logic [15:0] iy_in,
  input  logic [7:0]  a_in,
  input  logic [7:0]  b_in,
  input  logic [7:0]  ccr_in,
  input  logic        irq,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  output logic        mem_en,
  output logic        mem_we,
  output logic [15:0] ret_out,
  output logic [15:0] ix_out,
  output logic [15:0] iy_out,
  output logic [7:0]  a_out,
  output logic [7:0]  b_out,
  output logic [7:0]  ccr_out,
  output logic        done,
  output logic        busy,
  output logic        waiting,
  output logic [15:0] sp
);
  localparam int FRAME = 9;
  localparam logic [3:0] SHORT_LAST = 4'd1;
  localparam logic [3:0] LONG_LAST  = 4'(FRAME - 1);

  typedef enum logic [1:0] {S_IDLE, S_MOVE, S_HOLD} st_t;

  st_t         st;
  logic        pull_q, wai_q, done_q;
  logic [3:0]  cnt_q, last_q;
  logic [15:0] sp_q;
  logic [7:0]  fr [FRAME];

  wire op_call = (cmd_op == 8'h9D) || (cmd_op == 8'hAD) || (cmd_op == 8'hBD) || (cmd_op == 8'h8D);
  wire op_rts  = (cmd_op == 8'h39);
  wire op_swi  = (cmd_op == 8'h3F);
  wire op_wai  = (cmd_op == 8'h3E);
  wire op_rti  = (cmd_op == 8'h3B);
  wire op_pull = op_rts || op_rti;
  wire take    = (st == S_IDLE) && cmd_valid && (op_call || op_rts || op_swi || op_wai || op_rti);

  wire        final_byte = (st == S_MOVE) && (cnt_q == last_q);
  wire [3:0]  slot = pull_q ? (last_q - cnt_q) : cnt_q;
  wire [15:0] step = {12'd0, last_q} + 16'd1;

  assign mem_en    = (st == S_MOVE);
  assign mem_we    = mem_en && !pull_q;
  assign mem_addr  = pull_q ? (sp_q + 16'd1 + {12'd0, cnt_q}) : (sp_q - {12'd0, cnt_q});
  assign mem_wdata = fr[slot];

  assign ret_out = {fr[1], fr[0]};
  assign iy_out  = {fr[3], fr[2]};
  assign ix_out  = {fr[5], fr[4]};
  assign a_out   = fr[6];
  assign b_out   = fr[7];
  assign ccr_out = fr[8];
  assign done    = done_q;
  assign busy    = (st != S_IDLE);
  assign waiting = (st == S_HOLD);
  assign sp      = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pull_q <= 1'b0;
      wai_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= 4'd0;
      last_q <= SHORT_LAST;
      sp_q   <= SP_INIT;
      for (int i = 0; i < FRAME; i++) fr[i] <= 8'd0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          pull_q <= op_pull;
          wai_q  <= op_wai;
          last_q <= (op_call || op_rts) ? SHORT_LAST : LONG_LAST;
          cnt_q  <= 4'd0;
          st     <= S_MOVE;
          if (!op_pull) begin
            fr[0] <= ret_in[7:0];
            fr[1] <= ret_in[15:8];
            fr[2] <= iy_in[7:0];
            fr[3] <= iy_in[15:8];
            fr[4] <= ix_in[7:0];
            fr[5] <= ix_in[15:8];
            fr[6] <= a_in;
            fr[7] <= b_in;
            fr[8] <= ccr_in;
          end
        end
        S_MOVE: begin
          if (pull_q) fr[slot] <= mem_rdata;
          if (final_byte) begin
            sp_q   <= pull_q ? (sp_q + step) : (sp_q - step);
            done_q <= 1'b1;
            st     <= wai_q ? S_HOLD : S_IDLE;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        S_HOLD: if (irq) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        irq,
  input logic [15:0] mem_addr,
  input logic        mem_en,
  input logic        mem_we,
  input logic        done,
  input logic        busy,
  input logic        waiting,
  input logic [15:0] sp
);
  a_r6_access_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> busy);
  a_r6_write_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);
  a_r6_consecutive_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |->
      (mem_addr == $past(mem_addr) + 16'd1 || mem_addr == $past(mem_addr) - 16'd1));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_en));
  a_r7_sp_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> done);
  a_r2_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> (sp == $past(sp) - 16'd2 || sp == $past(sp) + 16'd2 ||
                      sp == $past(sp) - 16'd9 || sp == $past(sp) + 16'd9));
  a_r8_wait_is_busy: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (busy && !mem_en));
  a_r8_wait_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && irq) |=> !waiting);
endmodule

bind stack_seq stack_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .mem_addr(mem_addr), .mem_en(mem_en),
  .mem_we(mem_we), .done(done), .busy(busy), .waiting(waiting), .sp(sp)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [15:0] ret_in = 16'h0, ix_in = 16'h0, iy_in = 16'h0;
  logic [7:0] a_in = 8'h0, b_in = 8'h0, ccr_in = 8'h0;
  logic irq = 1'b0;
  logic [15:0] mem_addr, ret_out, ix_out, iy_out, sp;
  logic [7:0] mem_wdata, mem_rdata, a_out, b_out, ccr_out;
  logic mem_en, mem_we, done, busy, waiting;

  always #4 clk = ~clk;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .ret_in(ret_in), .ix_in(ix_in), .iy_in(iy_in), .a_in(a_in), .b_in(b_in),
    .ccr_in(ccr_in), .irq(irq), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we), .ret_out(ret_out),
    .ix_out(ix_out), .iy_out(iy_out), .a_out(a_out), .b_out(b_out),
    .ccr_out(ccr_out), .done(done), .busy(busy), .waiting(waiting), .sp(sp)
  );

  logic [7:0] mem [0:1023];
  assign mem_rdata = mem[mem_addr[9:0]];
  always @(posedge clk) if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] exp_sp = 16'h01FF;

  logic [15:0] qa[$];
  logic        qw[$];
  logic [7:0]  qd[$];
  string       qt[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mem_en) begin
      if (qa.size() == 0) begin
        chk(0, "R9", "unexpected access addr", {16'h0, mem_addr}, 32'h0);
      end else begin
        logic [15:0] ea; logic ew; logic [7:0] ed; string et;
        ea = qa.pop_front(); ew = qw.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
        chk(mem_addr == ea, et, "access addr", {16'h0, mem_addr}, {16'h0, ea});
        chk(mem_we == ew, "R6", "write enable", {31'h0, mem_we}, {31'h0, ew});
        if (ew) chk(mem_wdata == ed, et, "write data", {24'h0, mem_wdata}, {24'h0, ed});
      end
    end
  end

  task automatic issue(input logic [7:0] op, input logic [15:0] r, input logic [15:0] x,
                       input logic [15:0] y, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] c, input string tag);
    logic [7:0] fb [9];
    int len;
    bit pull;
    fb[0] = r[7:0]; fb[1] = r[15:8]; fb[2] = y[7:0]; fb[3] = y[15:8];
    fb[4] = x[7:0]; fb[5] = x[15:8]; fb[6] = a; fb[7] = b; fb[8] = c;
    pull = (op == 8'h39) || (op == 8'h3B);
    len  = (op == 8'h39 || op == 8'h9D || op == 8'hAD || op == 8'hBD || op == 8'h8D) ? 2 : 9;
    for (int k = 0; k < len; k++) begin
      if (pull) begin
        qa.push_back(exp_sp + 16'd1 + 16'(k)); qw.push_back(1'b0); qd.push_back(8'h0);
      end else begin
        qa.push_back(exp_sp - 16'(k)); qw.push_back(1'b1); qd.push_back(fb[k]);
      end
      qt.push_back(tag);
    end
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; ret_in = r; ix_in = x; iy_in = y;
    a_in = a; b_in = b; ccr_in = c;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    for (int k = 0; k < len; k++) @(negedge clk);
    @(negedge clk);
    exp_sp = pull ? exp_sp + 16'(len) : exp_sp - 16'(len);
    chk(done == 1'b1, "R7", "done after last byte", {31'h0, done}, 32'h1);
    chk(sp == exp_sp, tag, "stack pointer", {16'h0, sp}, {16'h0, exp_sp});
    chk(qa.size() == 0, "R6", "bytes outstanding", qa.size(), 32'h0);
    @(negedge clk);
    chk(done == 1'b0, "R7", "done one cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      chk(0, "R7", "watchdog expired", 32'h1, 32'h0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 16'h01FF, "R1", "reset sp", {16'h0, sp}, 32'h01FF);
    chk(!busy && !done && !waiting && !mem_en, "R1", "reset flags",
        {28'h0, busy, done, waiting, mem_en}, 32'h0);

    issue(8'h9D, 16'h1234, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R2");
    chk(mem[10'h1FF] == 8'h34 && mem[10'h1FE] == 8'h12, "R2", "call bytes",
        {16'h0, mem[10'h1FF], mem[10'h1FE]}, 32'h3412);
    issue(8'h8D, 16'hABCD, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R2");
    issue(8'h39, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R3");
    chk(ret_out == 16'hABCD, "R3", "nested return", {16'h0, ret_out}, 32'hABCD);
    issue(8'h39, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R3");
    chk(ret_out == 16'h1234, "R3", "outer return", {16'h0, ret_out}, 32'h1234);

    fork
      issue(8'h3F, 16'hC0DE, 16'h1122, 16'h3344, 8'h55, 8'h66, 8'h77, "R4");
      begin
        repeat (3) @(posedge clk);
        #2 cmd_valid = 1'b1; cmd_op = 8'h9D;
        @(posedge clk);
        #2 cmd_valid = 1'b0;
      end
    join
    chk(sp == 16'h01F6, "R9", "command during push ignored", {16'h0, sp}, 32'h01F6);

    issue(8'hAD, 16'h0F0F, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R2");
    issue(8'h39, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R3");
    chk(ret_out == 16'h0F0F, "R3", "return over frame", {16'h0, ret_out}, 32'h0F0F);
    issue(8'h3B, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R5");
    chk(ret_out == 16'hC0DE, "R5", "ret restored", {16'h0, ret_out}, 32'hC0DE);
    chk(ix_out == 16'h1122, "R5", "ix restored", {16'h0, ix_out}, 32'h1122);
    chk(iy_out == 16'h3344, "R5", "iy restored", {16'h0, iy_out}, 32'h3344);
    chk({a_out, b_out, ccr_out} == 24'h556677, "R5", "a b ccr restored",
        {8'h0, a_out, b_out, ccr_out}, 32'h556677);

    issue(8'h3E, 16'h2468, 16'h1357, 16'h9ABC, 8'h01, 8'h02, 8'h03, "R8");
    for (int k = 0; k < 5; k++) begin
      chk(waiting && busy, "R8", "holding wait", {30'h0, waiting, busy}, 32'h3);
      @(negedge clk);
    end
    cmd_valid = 1'b1; cmd_op = 8'h3B;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(sp == 16'h01F6 && waiting, "R9", "command during wait ignored", {16'h0, sp}, 32'h01F6);
    @(posedge clk); #1 irq = 1'b1;
    @(negedge clk);
    chk(waiting == 1'b1, "R8", "wait before irq edge", {31'h0, waiting}, 32'h1);
    @(negedge clk);
    chk(!waiting && !busy, "R8", "released by irq", {30'h0, waiting, busy}, 32'h0);
    irq = 1'b0;

    issue(8'hBD, 16'h7777, 16'hFFFF, 16'hFFFF, 8'hFF, 8'hFF, 8'hFF, "R2");
    issue(8'h39, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R3");
    chk(ret_out == 16'h7777, "R3", "return above wait frame", {16'h0, ret_out}, 32'h7777);
    issue(8'h3B, 16'h0, 16'h0, 16'h0, 8'h0, 8'h0, 8'h0, "R5");
    chk({ret_out, ix_out} == 32'h24681357, "R8", "wait frame ret ix", {ret_out, ix_out}, 32'h24681357);
    chk({iy_out, a_out, b_out} == 32'h9ABC0102, "R8", "wait frame iy a b",
        {iy_out, a_out, b_out}, 32'h9ABC0102);
    chk(ccr_out == 8'h03 && sp == 16'h01FF, "R5", "ccr and sp", {8'h0, ccr_out, sp}, 32'h000301FF);

    @(posedge clk); #1 cmd_valid = 1'b1; cmd_op = 8'h00;
    @(posedge clk); #1 cmd_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(sp == 16'h01FF && !busy && !done, "R9", "unknown opcode ignored", {16'h0, sp}, 32'h01FF);
    chk(ret_out == 16'h2468 && ix_out == 16'h1357, "R10", "outputs held",
        {ret_out, ix_out}, 32'h24681357);
    chk(ccr_out == 8'h03 && b_out == 8'h02, "R10", "bytes held", {16'h0, ccr_out, b_out}, 32'h0302);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule